// File: doc/BRIEF.md
# Companion GPIO and Control Register Block

This peripheral sits on a 16-bit synchronous register bus. It stores a small set of control words: mode, clock divider, clock control, a power word, and three interrupt words. It also returns a fixed status word and contains a 16-line general-purpose I/O unit. Only the low six address bits are decoded, so the register window repeats every 64 bytes. Write data arrives on a wider bus and is cut to 16 bits before it is stored. A read returns its data one cycle after the strobe. An access to an offset with no register behind it raises a one-cycle error pulse.

The GPIO unit keeps a direction word and a level word. Each output pin carries level AND direction. The outputs are evaluated again only after a bus write to the direction or level register. In that evaluation, only the pins whose gated value differs from the value last driven are updated, and each updated pin shows a one-cycle change pulse. External input lines can set or clear level bits directly. They ignore the direction mask and do not trigger an output update.

A two-state GPIO machine sequences the updates. HOLD moves to EVAL on any direction or level write, and EVAL stays in EVAL if another such write arrives; otherwise it returns to HOLD. While in EVAL, the changed outputs are refreshed. A three-state response machine runs the bus side. IDLE, DATA and ERR each move to ERR on an unmapped access, to DATA on a mapped read, and to IDLE otherwise. The error output is high while the machine is in ERR.

Top module: `gpio_ctl_regs`

## Requirements
- R1: Only bus_addr[5:0] is decoded. The register offsets are: mode 0x00, clock divider 0x04, status 0x08, power 0x0C, clock control 0x10, interrupt request 0x14, interrupt mask 0x18, interrupt status 0x1C, direction 0x20, level-write 0x24, level-read 0x28. An address such as 0x044 reaches the same register as 0x004.
- R2: Only bus_wdata[15:0] is stored; bits above 15 have no effect on any register.
- R3: A power write stores the value. If bit 7 of the value is 1, bits 15 and 6 of the stored value are also set.
- R4: The status offset always reads 0x0002; writes to it change nothing.
- R5: A write to offset 0x24 or 0x28 stores (write data AND direction) into the level register.
- R6: Reads of 0x24 and 0x28 both return the level register; a read of 0x20 returns the direction register.
- R7: After a direction or level write in bus cycle N, gpio_out equals level AND direction from the end of cycle N, and this becomes visible after clock edge N+1 and not before.
- R8: In an update, gpio_chg pulses for one cycle on exactly the pins whose value changed. With no update, gpio_chg stays 0.
- R9: When pin_upd[i] is 1, level bit i takes the value of pin_val[i]. This is not masked by direction and does not change gpio_out. If a level write happens in the same cycle, the input line wins for that bit.
- R10: An unmapped offset (including the non-aligned offsets) reads 0 and ignores writes. The access drives bus_err high for exactly the following cycle; mapped accesses leave it low.
- R11: Synchronous active-high reset clears all registers, gpio_out, gpio_chg, bus_rdata and bus_err to 0. Status still reads 0x0002.
- R12: bus_rdata updates on the cycle after bus_re and holds its value while bus_re is low.
- R13: Mode, clock divider, clock control and the three interrupt words read back exactly what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address; low 6 bits decoded |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | BUS_W (32) | Write data, truncated to 16 bits |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| pin_val | input | GPIO_N (16) | Value for input-line level updates |
| pin_upd | input | GPIO_N (16) | Per-line update enable for level bits |
| gpio_out | output | GPIO_N (16) | Gated GPIO outputs |
| gpio_chg | output | GPIO_N (16) | One-cycle marker of outputs that changed |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 32-bit write bus and 16 GPIO lines. The address bits above bit 5 let the bench drive aliased addresses such as 0x044 and 0xFC4. The upper half of the write bus lets it drive junk that must be dropped. The full set of 16 lines lets it put pins inside and outside the direction mask in a single word, so masked writes, unmasked input-line updates and a partial output refresh can all be seen at the ports.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam int REG_W = 16;
    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
    localparam logic [OFS_W-1:0] OFS_CDIV = 6'h04;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h08;
    localparam logic [OFS_W-1:0] OFS_PWR  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_CCTL = 6'h10;
    localparam logic [OFS_W-1:0] OFS_IREQ = 6'h14;
    localparam logic [OFS_W-1:0] OFS_IMSK = 6'h18;
    localparam logic [OFS_W-1:0] OFS_ISTA = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_GDIR = 6'h20;
    localparam logic [OFS_W-1:0] OFS_GWR  = 6'h24;
    localparam logic [OFS_W-1:0] OFS_GRD  = 6'h28;

    localparam logic [REG_W-1:0] STAT_VALUE = 16'h0002;

    localparam int PWR_TRIG_BIT = 7;
    localparam int PWR_HI_BIT   = 15;
    localparam int PWR_LO_BIT   = 6;
    localparam logic [REG_W-1:0] PWR_FORCE_MASK =
        REG_W'((1 << PWR_HI_BIT) | (1 << PWR_LO_BIT));

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_CDIV,
        SEL_STAT,
        SEL_PWR,
        SEL_CCTL,
        SEL_IREQ,
        SEL_IMSK,
        SEL_ISTA,
        SEL_GDIR,
        SEL_GLVL
    } reg_sel_e;

    localparam int N_PLAIN = 6;
    localparam int PL_MODE = 0;
    localparam int PL_CDIV = 1;
    localparam int PL_CCTL = 2;
    localparam int PL_IREQ = 3;
    localparam int PL_IMSK = 4;
    localparam int PL_ISTA = 5;
    localparam reg_sel_e PLAIN_SEL [N_PLAIN] =
        '{SEL_MODE, SEL_CDIV, SEL_CCTL, SEL_IREQ, SEL_IMSK, SEL_ISTA};

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_DATA,
        RSP_ERR
    } rsp_state_e;

    typedef enum logic {
        GP_HOLD,
        GP_EVAL
    } gp_state_e;

endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
    import gcr_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    output reg_sel_e         sel,
    output logic             mapped
);

    always_comb begin
        unique case (ofs)
            OFS_MODE: sel = SEL_MODE;
            OFS_CDIV: sel = SEL_CDIV;
            OFS_STAT: sel = SEL_STAT;
            OFS_PWR:  sel = SEL_PWR;
            OFS_CCTL: sel = SEL_CCTL;
            OFS_IREQ: sel = SEL_IREQ;
            OFS_IMSK: sel = SEL_IMSK;
            OFS_ISTA: sel = SEL_ISTA;
            OFS_GDIR: sel = SEL_GDIR;
            OFS_GWR:  sel = SEL_GLVL;
            OFS_GRD:  sel = SEL_GLVL;
            default:  sel = SEL_NONE;
        endcase
    end

    assign mapped = (sel != SEL_NONE);

endmodule

// File: rtl/gcr_ctl_regs.sv
module gcr_ctl_regs
    import gcr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  reg_sel_e                       sel,
    input  logic [REG_W-1:0]               wdata,
    output logic [N_PLAIN-1:0][REG_W-1:0]  plain_q,
    output logic [REG_W-1:0]               pwr_q
);

    // plain storage words: one cell per slot
    for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
        logic [REG_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (wr_en && (sel == PLAIN_SEL[g])) begin
                cell_q <= wdata;
            end
        end
        assign plain_q[g] = cell_q;
    end

    // power word: trigger bit forces the two companion bits
    logic [REG_W-1:0] pwr_next;
    always_comb begin
        pwr_next = wdata;
        if (wdata[PWR_TRIG_BIT]) begin
            pwr_next = wdata | PWR_FORCE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= '0;
        end else if (wr_en && (sel == SEL_PWR)) begin
            pwr_q <= pwr_next;
        end
    end

endmodule

// File: rtl/gcr_gpio.sv
module gcr_gpio
    import gcr_pkg::*;
#(
    parameter int GPIO_N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_we,
    input  logic              lvl_we,
    input  logic [GPIO_N-1:0] wdata,
    input  logic [GPIO_N-1:0] pin_val,
    input  logic [GPIO_N-1:0] pin_upd,
    output logic [GPIO_N-1:0] dir_q,
    output logic [GPIO_N-1:0] lvl_q,
    output logic [GPIO_N-1:0] gpio_out,
    output logic [GPIO_N-1:0] gpio_chg
);

    gp_state_e state_q, state_d;
    logic      any_wr;

    assign any_wr = dir_we || lvl_we;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GP_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        unique case (state_q)
            GP_HOLD: state_d = any_wr ? GP_EVAL : GP_HOLD;
            GP_EVAL: state_d = any_wr ? GP_EVAL : GP_HOLD;
            default: state_d = GP_HOLD;
        endcase
    end

    // direction register
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
        end else if (dir_we) begin
            dir_q <= wdata;
        end
    end

    // level register: bus write masked by direction, input lines override per bit
    logic [GPIO_N-1:0] lvl_bus;
    assign lvl_bus = lvl_we ? (wdata & dir_q) : lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= (lvl_bus & ~pin_upd) | (pin_val & pin_upd);
        end
    end

    // output cells: refresh only pins whose gated value moved
    logic [GPIO_N-1:0] gated;
    logic [GPIO_N-1:0] diff;
    logic              eval_now;

    assign gated    = lvl_q & dir_q;
    assign diff     = gated ^ gpio_out;
    assign eval_now = (state_q == GP_EVAL);

    for (genvar i = 0; i < GPIO_N; i++) begin : g_out
        logic pin_q;
        logic chg_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pin_q <= 1'b0;
                chg_q <= 1'b0;
            end else begin
                chg_q <= eval_now && diff[i];
                if (eval_now && diff[i]) begin
                    pin_q <= gated[i];
                end
            end
        end
        assign gpio_out[i] = pin_q;
        assign gpio_chg[i] = chg_q;
    end

endmodule

// File: rtl/gcr_bus_rsp.sv
module gcr_bus_rsp
    import gcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             re,
    input  logic             mapped,
    input  logic [REG_W-1:0] rd_val,
    output logic [REG_W-1:0] rdata,
    output logic             err
);

    rsp_state_e state_q, state_d;
    logic       bad_acc;

    assign bad_acc = (we || re) && !mapped;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE,
            RSP_DATA,
            RSP_ERR: begin
                if (bad_acc) begin
                    state_d = RSP_ERR;
                end else if (re) begin
                    state_d = RSP_DATA;
                end else begin
                    state_d = RSP_IDLE;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mapped ? rd_val : '0;
        end
    end

    assign err = (state_q == RSP_ERR);

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
    import gcr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32,
    parameter int GPIO_N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic [GPIO_N-1:0] pin_val,
    input  logic [GPIO_N-1:0] pin_upd,
    output logic [GPIO_N-1:0] gpio_out,
    output logic [GPIO_N-1:0] gpio_chg
);

    // address bits above the window and write bits above the register
    // width take no part in the function
    logic addr_unused;
    logic wdata_unused;
    assign addr_unused  = ^bus_addr[ADDR_W-1:OFS_W];
    assign wdata_unused = ^bus_wdata[BUS_W-1:REG_W];

    logic [REG_W-1:0] wd;
    assign wd = bus_wdata[REG_W-1:0];

    reg_sel_e sel;
    logic     mapped;

    gcr_decode u_dec (
        .ofs    (bus_addr[OFS_W-1:0]),
        .sel    (sel),
        .mapped (mapped)
    );

    logic [N_PLAIN-1:0][REG_W-1:0] plain_q;
    logic [REG_W-1:0]              pwr_q;

    gcr_ctl_regs u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we),
        .sel     (sel),
        .wdata   (wd),
        .plain_q (plain_q),
        .pwr_q   (pwr_q)
    );

    logic [GPIO_N-1:0] gp_dir;
    logic [GPIO_N-1:0] gp_lvl;

    gcr_gpio #(.GPIO_N(GPIO_N)) u_gpio (
        .clk      (clk),
        .rst      (rst),
        .dir_we   (bus_we && (sel == SEL_GDIR)),
        .lvl_we   (bus_we && (sel == SEL_GLVL)),
        .wdata    (wd[GPIO_N-1:0]),
        .pin_val  (pin_val),
        .pin_upd  (pin_upd),
        .dir_q    (gp_dir),
        .lvl_q    (gp_lvl),
        .gpio_out (gpio_out),
        .gpio_chg (gpio_chg)
    );

    logic [REG_W-1:0] rd_val;
    always_comb begin
        unique case (sel)
            SEL_MODE: rd_val = plain_q[PL_MODE];
            SEL_CDIV: rd_val = plain_q[PL_CDIV];
            SEL_CCTL: rd_val = plain_q[PL_CCTL];
            SEL_IREQ: rd_val = plain_q[PL_IREQ];
            SEL_IMSK: rd_val = plain_q[PL_IMSK];
            SEL_ISTA: rd_val = plain_q[PL_ISTA];
            SEL_STAT: rd_val = STAT_VALUE;
            SEL_PWR:  rd_val = pwr_q;
            SEL_GDIR: rd_val = REG_W'(gp_dir);
            SEL_GLVL: rd_val = REG_W'(gp_lvl);
            default:  rd_val = '0;
        endcase
    end

    gcr_bus_rsp u_rsp (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .re     (bus_re),
        .mapped (mapped),
        .rd_val (rd_val),
        .rdata  (bus_rdata),
        .err    (bus_err)
    );

endmodule

// File: rtl/gcr_sva.sv
module gcr_sva
    import gcr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32,
    parameter int GPIO_N = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              bus_err,
    input logic [GPIO_N-1:0] pin_upd,
    input logic [GPIO_N-1:0] gpio_out,
    input logic [GPIO_N-1:0] gpio_chg,
    input logic [GPIO_N-1:0] gp_dir,
    input logic [GPIO_N-1:0] gp_lvl,
    input logic [REG_W-1:0]  pwr_q
);

    logic [OFS_W-1:0] ofs;
    logic             lvl_wr;
    logic             gp_wr;

    assign ofs    = bus_addr[OFS_W-1:0];
    assign lvl_wr = bus_we && ((ofs == OFS_GWR) || (ofs == OFS_GRD));
    assign gp_wr  = lvl_wr || (bus_we && (ofs == OFS_GDIR));

    AST_PWR_FORCE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (ofs == OFS_PWR) && bus_wdata[PWR_TRIG_BIT])
        |=> (pwr_q[PWR_HI_BIT] && pwr_q[PWR_LO_BIT])); // R3

    AST_STAT_FIXED: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (ofs == OFS_STAT)) |=> (bus_rdata == STAT_VALUE)); // R4

    AST_LVL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (lvl_wr && (pin_upd == '0)) |=> ((gp_lvl & ~gp_dir) == '0)); // R5

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        gp_wr |=> ##1 (gpio_out == $past(gp_lvl & gp_dir))); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !gp_wr |=> ##1 $stable(gpio_out)); // R9

    AST_CHG_EXACT: assert property (@(posedge clk) disable iff (rst)
        gpio_chg == (gpio_out ^ $past(gpio_out))); // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_we || bus_re)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata)); // R12

endmodule

bind gpio_ctl_regs gcr_sva #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .GPIO_N (GPIO_N)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .pin_upd   (pin_upd),
    .gpio_out  (gpio_out),
    .gpio_chg  (gpio_chg),
    .gp_dir    (gp_dir),
    .gp_lvl    (gp_lvl),
    .pwr_q     (pwr_q)
);

// File: tb/gpio_ctl_regs_tb.sv
module gpio_ctl_regs_tb;

    localparam int ADDR_W = 12;
    localparam int BUS_W  = 32;
    localparam int GPIO_N = 16;
    localparam int WD_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_we;
    logic              bus_re;
    logic [BUS_W-1:0]  bus_wdata;
    logic [15:0]       bus_rdata;
    logic              bus_err;
    logic [GPIO_N-1:0] pin_val;
    logic [GPIO_N-1:0] pin_upd;
    logic [GPIO_N-1:0] gpio_out;
    logic [GPIO_N-1:0] gpio_chg;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_ctl_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .GPIO_N(GPIO_N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .pin_val   (pin_val),
        .pin_upd   (pin_upd),
        .gpio_out  (gpio_out),
        .gpio_chg  (gpio_chg)
    );

    // {kind 1=write 2=read, addr, wdata, expected read}
    localparam int NV = 27;
    localparam logic [63:0] VEC [NV] = '{
        {4'h1, 12'h000, 32'hABCD_1234, 16'h0000},  // R2 R13 upper half dropped
        {4'h2, 12'h000, 32'h0,         16'h1234},
        {4'h1, 12'h004, 32'h0000_00FF, 16'h0000},
        {4'h2, 12'h044, 32'h0,         16'h00FF},  // R1 alias
        {4'h1, 12'h00C, 32'hFFFF_0081, 16'h0000},  // R3 trigger set
        {4'h2, 12'h00C, 32'h0,         16'h80C1},
        {4'h1, 12'h00C, 32'h0000_0041, 16'h0000},  // R3 trigger clear
        {4'h2, 12'h00C, 32'h0,         16'h0041},
        {4'h1, 12'h008, 32'h0000_FFFF, 16'h0000},  // R4
        {4'h2, 12'h008, 32'h0,         16'h0002},
        {4'h1, 12'h010, 32'h0000_5A5A, 16'h0000},  // R13
        {4'h2, 12'h010, 32'h0,         16'h5A5A},
        {4'h1, 12'h014, 32'h0000_1111, 16'h0000},
        {4'h1, 12'h018, 32'h0000_2222, 16'h0000},
        {4'h1, 12'h01C, 32'h0000_3333, 16'h0000},
        {4'h2, 12'h014, 32'h0,         16'h1111},
        {4'h2, 12'h018, 32'h0,         16'h2222},
        {4'h2, 12'h01C, 32'h0,         16'h3333},
        {4'h1, 12'h020, 32'h0003_00FF, 16'h0000},  // R6 direction
        {4'h2, 12'h020, 32'h0,         16'h00FF},
        {4'h1, 12'h024, 32'h0000_F0F0, 16'h0000},  // R5 masked level
        {4'h2, 12'h028, 32'h0,         16'h00F0},
        {4'h1, 12'h028, 32'h0000_0F0F, 16'h0000},  // R5 second alias
        {4'h2, 12'h024, 32'h0,         16'h000F},
        {4'h2, 12'h02C, 32'h0,         16'h0000},  // R10 unmapped
        {4'h1, 12'h030, 32'h0000_FFFF, 16'h0000},
        {4'h2, 12'h030, 32'h0,         16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic pins(input logic [GPIO_N-1:0] m, input logic [GPIO_N-1:0] v);
        @(negedge clk);
        pin_upd = m;
        pin_val = v;
        @(negedge clk);
        pin_upd = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        rst       = 1'b1;
        bus_addr  = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_wdata = '0;
        pin_val   = '0;
        pin_upd   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset gpio_out", gpio_out, 16'h0000);
        chk("R11 reset gpio_chg", gpio_chg, 16'h0000);
        chk("R11 reset rdata", bus_rdata, 16'h0000);
        chk("R11 reset err", {15'd0, bus_err}, 16'h0000);
        rst = 1'b0;

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [63:0] v;
            v = VEC[i];
            if (v[63:60] == 4'h1) begin
                bus_wr(v[59:48], v[47:16]);
            end else begin
                bus_rd(v[59:48], rd);
                chk($sformatf("table[%0d] R1-R13 readback", i), rd, v[15:0]);
            end
        end

        // R7 R8: output latency and partial refresh
        chk("R7 out after table", gpio_out, 16'h000F);
        bus_wr(12'h020, 32'h0000_FFFF);
        chk("R7 no early update", gpio_out, 16'h000F);
        @(negedge clk);
        chk("R7 same gated value", gpio_out, 16'h000F);
        chk("R8 no change pulse", gpio_chg, 16'h0000);
        bus_wr(12'h024, 32'h0000_FF00);
        chk("R7 no early update lvl", gpio_out, 16'h000F);
        @(negedge clk);
        chk("R7 out after level write", gpio_out, 16'hFF00);
        chk("R8 changed pins", gpio_chg, 16'hFF0F);
        @(negedge clk);
        chk("R8 pulse one cycle", gpio_chg, 16'h0000);

        // R9: input lines bypass mask and do not refresh outputs
        bus_wr(12'h020, 32'h0000_00FF);
        @(negedge clk);
        chk("R7 dir shrink out", gpio_out, 16'h0000);
        chk("R8 dir shrink chg", gpio_chg, 16'hFF00);
        pins(16'h0011, 16'h0011);
        pins(16'h0100, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R9 out untouched by pins", gpio_out, 16'h0000);
        chk("R9 no chg from pins", gpio_chg, 16'h0000);
        bus_rd(12'h028, rd);
        chk("R9 level unmasked", rd, 16'hFE11);
        bus_wr(12'h020, 32'h0000_00FF);
        @(negedge clk);
        chk("R9 refresh after dir write", gpio_out, 16'h0011);
        chk("R8 refresh chg", gpio_chg, 16'h0011);

        // R9: input line wins over same-cycle level write
        @(negedge clk);
        bus_addr  = 12'h024;
        bus_wdata = 32'h0000_0000;
        bus_we    = 1'b1;
        pin_upd   = 16'h0008;
        pin_val   = 16'h0008;
        @(negedge clk);
        bus_we    = 1'b0;
        pin_upd   = '0;
        @(negedge clk);
        chk("R9 collision out", gpio_out, 16'h0008);
        bus_rd(12'h024, rd);
        chk("R9 collision level", rd, 16'h0008);

        // R10: unmapped accesses
        bus_wr(12'h02C, 32'h0000_FFFF);
        chk("R10 err after bad write", {15'd0, bus_err}, 16'h0001);
        @(negedge clk);
        chk("R10 err one cycle", {15'd0, bus_err}, 16'h0000);
        bus_wr(12'h002, 32'h0000_7777);
        chk("R10 err misaligned", {15'd0, bus_err}, 16'h0001);
        bus_rd(12'h000, rd);
        chk("R10 misaligned write ignored", rd, 16'h1234);
        chk("R10 no err on mapped read", {15'd0, bus_err}, 16'h0000);
        bus_rd(12'h03C, rd);
        chk("R10 unmapped read zero", rd, 16'h0000);
        chk("R10 err on bad read", {15'd0, bus_err}, 16'h0001);
        bus_rd(12'h028, rd);
        chk("R10 level untouched", rd, 16'h0008);

        // R12: read data holds
        bus_rd(12'h010, rd);
        chk("R12 read value", rd, 16'h5A5A);
        repeat (3) @(negedge clk);
        chk("R12 rdata holds", bus_rdata, 16'h5A5A);

        // R1: high alias write
        bus_wr(12'hFC4, 32'h0000_00AA);
        bus_rd(12'h004, rd);
        chk("R1 alias write", rd, 16'h00AA);

        // R11: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 out cleared", gpio_out, 16'h0000);
        chk("R11 rdata cleared", bus_rdata, 16'h0000);
        rst = 1'b0;
        bus_rd(12'h000, rd);
        chk("R11 mode cleared", rd, 16'h0000);
        bus_rd(12'h00C, rd);
        chk("R11 power cleared", rd, 16'h0000);
        bus_rd(12'h020, rd);
        chk("R11 dir cleared", rd, 16'h0000);
        bus_rd(12'h008, rd);
        chk("R11 status after reset", rd, 16'h0002);

        finish_run();
    end

endmodule